// File: doc/BRIEF.md
# Range-Based Cache Maintenance Sequencer

This block carries out one cache-maintenance request over an address range given as a low and a high address. Each accepted request handles at most one cache line: the line that holds the low address. When it finishes, the block returns the start of the following line as the new low address. Software keeps reissuing the request with the returned value until it is no longer below the high address. Because the block computes the step itself, the caller never needs to know the line size.

Three operations are supported: invalidate, writeback (clean), and flush (writeback followed by invalidate). The block first probes a tag/data array through a line-operation port. The array answers in the same cycle with hit and dirty flags. The block then issues a writeback command, which it holds until the array acknowledges it, and then an invalidate pulse. Invalidate and flush also send a pulse on a side output that drops the matching instruction-cache line.

An invalidate is destructive. When it hits a dirty line that the range covers only in part, the block treats that line as a flush, so bytes outside the range are not lost. Address translation, coherence traffic and the arrays themselves are outside the block.

Top module: `cmo_range_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` stays low from the next cycle until the cycle after `done_valid`.
- R2: If `req_lo >= req_hi`, or `req_op` is 3 (reserved), the block makes no probe and no line command. `done_valid` rises in the cycle right after acceptance, with `done_lo` equal to `req_lo`.
- R3: For any other request, `done_lo` is `req_lo` aligned down to `LINE_BYTES` plus `LINE_BYTES`. Repeating the request over a range therefore visits each line exactly once.
- R4: Writeback (`req_op`=1) on a line that hits and is dirty issues one writeback. It never pulses `arr_inv` or `ic_inv`. On a miss or a clean hit it issues no command.
- R5: Flush (`req_op`=2) writes back a line that hits and is dirty. It then invalidates the line if it hits, and always pulses `ic_inv`.
- R6: Invalidate (`req_op`=0) on a line that hits and is dirty writes the line back first, then invalidates it. This applies when the line is only partly covered, meaning `req_lo` is not line-aligned or `req_hi` lies before the line's end.
- R7: Invalidate on a line that the range covers fully drops the line with no writeback, even if the line is dirty.
- R8: `arr_wb_req` stays high until a cycle in which `arr_wb_ack` is high. `done_valid` never comes before that acknowledgement.
- R9: `arr_wb_req` and `arr_inv` are never high in the same cycle. An invalidate that follows a writeback comes in the cycle after the acknowledgement.
- R10: Invalidate and flush pulse `ic_inv` for one cycle even when the data array misses. `arr_inv` pulses only on a hit.
- R11: `done_valid` is a one-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 invalidate, 1 writeback, 2 flush, 3 reserved |
| req_lo | input | ADDR_W | Range low address |
| req_hi | input | ADDR_W | Range high address (exclusive) |
| done_valid | output | 1 | Result pulse |
| done_lo | output | ADDR_W | Updated low address |
| arr_addr | output | ADDR_W | Line-aligned address for array and instruction cache |
| arr_probe | output | 1 | Lookup of `arr_addr` this cycle |
| arr_hit | input | 1 | Line present (same cycle as probe) |
| arr_dirty | input | 1 | Line dirty (same cycle as probe) |
| arr_wb_req | output | 1 | Writeback command, held until acknowledged |
| arr_wb_ack | input | 1 | Writeback accepted |
| arr_inv | output | 1 | Data line invalidate pulse |
| ic_inv | output | 1 | Instruction-cache line invalidate pulse |

## Verification
Once a request is accepted at an edge, a bypassed request shows `done_valid` in the very next cycle. Any other request shows the probe in that next cycle. Then come `arr_wb_req` for the acknowledge delay plus one cycle when a writeback is due, one invalidate cycle when invalidation is due, and the `done_valid` cycle. The bench builds this exact per-cycle trace from the requirements and its own array model before it issues each request. It then compares every output on the falling edge of every cycle until the block is idle again, so a result that arrives a cycle early or late counts as a mismatch. The acknowledge delay varies between requests to stretch the writeback window.

// File: rtl/cmo_seq_pkg.sv
package cmo_seq_pkg;

  typedef enum logic [1:0] {
    CMO_INVAL = 2'd0,
    CMO_CLEAN = 2'd1,
    CMO_FLUSH = 2'd2,
    CMO_RSVD  = 2'd3
  } cmo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROBE = 3'd1,
    ST_WB    = 3'd2,
    ST_INV   = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/cmo_line_geom.sv
module cmo_line_geom #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] next,
  output logic              partial,
  output logic              empty_rng
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [ADDR_W:0] next_ext;
  logic [ADDR_W:0] hi_ext;

  always_comb begin
    base      = {lo[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    next_ext  = {1'b0, base} + (ADDR_W+1)'(LINE_BYTES);
    hi_ext    = {1'b0, hi};
    next      = next_ext[ADDR_W-1:0];
    // Edge line: range starts inside it or ends before its end.
    partial   = (lo[OFF_W-1:0] != '0) || (hi_ext < next_ext);
    empty_rng = (lo >= hi);
  end
endmodule

// File: rtl/cmo_action_dec.sv
module cmo_action_dec
  import cmo_seq_pkg::*;
(
  input  cmo_op_e op,
  input  logic    partial,
  input  logic    hit,
  input  logic    dirty,
  output logic    need_wb,
  output logic    need_dinv,
  output logic    need_iinv
);
  logic is_inval, is_flush, is_clean;

  always_comb begin
    is_inval  = (op == CMO_INVAL);
    is_flush  = (op == CMO_FLUSH);
    is_clean  = (op == CMO_CLEAN);
    // Destructive invalidate on an edge line is promoted to a flush.
    need_wb   = hit && dirty && (is_clean || is_flush || (is_inval && partial));
    need_dinv = hit && (is_inval || is_flush);
    need_iinv = is_inval || is_flush;
  end
endmodule

// File: rtl/cmo_seq_ctrl.sv
module cmo_seq_ctrl
  import cmo_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic skip,
  input  logic need_wb,
  input  logic need_dinv,
  input  logic need_iinv,
  input  logic wb_ack,
  output logic idle_o,
  output logic probe_o,
  output logic wb_o,
  output logic dinv_o,
  output logic iinv_o,
  output logic done_o
);
  seq_state_e state_q, state_d;
  logic       dinv_q, iinv_q;
  logic       flags_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = skip ? ST_DONE : ST_PROBE;
      ST_PROBE: begin
        if (need_wb)                     state_d = ST_WB;
        else if (need_dinv || need_iinv) state_d = ST_INV;
        else                             state_d = ST_DONE;
      end
      ST_WB:    if (wb_ack) state_d = (dinv_q || iinv_q) ? ST_INV : ST_DONE;
      ST_INV:   state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign flags_en = (state_q == ST_PROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dinv_q <= 1'b0;
      iinv_q <= 1'b0;
    end else if (flags_en) begin
      dinv_q <= need_dinv;
      iinv_q <= need_iinv;
    end
  end

  assign idle_o  = (state_q == ST_IDLE);
  assign probe_o = (state_q == ST_PROBE);
  assign wb_o    = (state_q == ST_WB);
  assign dinv_o  = (state_q == ST_INV) && dinv_q;
  assign iinv_o  = (state_q == ST_INV) && iinv_q;
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/cmo_range_seq.sv
module cmo_range_seq
  import cmo_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_lo,
  input  logic [ADDR_W-1:0] req_hi,
  output logic              done_valid,
  output logic [ADDR_W-1:0] done_lo,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_probe,
  input  logic              arr_hit,
  input  logic              arr_dirty,
  output logic              arr_wb_req,
  input  logic              arr_wb_ack,
  output logic              arr_inv,
  output logic              ic_inv
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [ADDR_W-1:0] g_base, g_next;
  logic              g_partial, g_empty;
  logic              accept, skip;
  cmo_op_e           in_op;

  cmo_line_geom #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_geom (
    .lo(req_lo), .hi(req_hi), .base(g_base), .next(g_next),
    .partial(g_partial), .empty_rng(g_empty)
  );

  assign in_op  = cmo_op_e'(req_op);
  assign accept = req_valid && req_ready;
  assign skip   = g_empty || (in_op == CMO_RSVD);

  cmo_op_e           op_q;
  logic [ADDR_W-1:0] base_q, res_q;
  logic              partial_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      op_q      <= CMO_INVAL;
      base_q    <= '0;
      res_q     <= '0;
      partial_q <= 1'b0;
    end else if (accept) begin
      op_q      <= in_op;
      base_q    <= g_base;
      res_q     <= skip ? req_lo : g_next;
      partial_q <= g_partial;
    end
  end

  logic need_wb, need_dinv, need_iinv;

  cmo_action_dec u_dec (
    .op(op_q), .partial(partial_q), .hit(arr_hit), .dirty(arr_dirty),
    .need_wb(need_wb), .need_dinv(need_dinv), .need_iinv(need_iinv)
  );

  cmo_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .start(accept), .skip(skip),
    .need_wb(need_wb), .need_dinv(need_dinv), .need_iinv(need_iinv),
    .wb_ack(arr_wb_ack), .idle_o(req_ready), .probe_o(arr_probe),
    .wb_o(arr_wb_req), .dinv_o(arr_inv), .iinv_o(ic_inv), .done_o(done_valid)
  );

  assign arr_addr = base_q;
  assign done_lo  = res_q;
endmodule

// File: rtl/cmo_range_seq_chk.sv
module cmo_range_seq_chk
  import cmo_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_lo,
  input logic [ADDR_W-1:0] req_hi,
  input logic              done_valid,
  input logic [ADDR_W-1:0] done_lo,
  input logic              arr_wb_req,
  input logic              arr_wb_ack,
  input logic              arr_inv,
  input logic              ic_inv,
  input cmo_op_e           op_q
);
  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_empty_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_lo >= req_hi) |=> done_valid && (done_lo == $past(req_lo)));

  assert_clean_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_inv || ic_inv) |-> (op_q != CMO_CLEAN));

  assert_inv_after_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_wb_req) && (op_q == CMO_INVAL) |-> ic_inv);

  assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wb_req && !arr_wb_ack |=> arr_wb_req && !done_valid);

  assert_wb_inv_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_wb_req && arr_inv));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
endmodule

bind cmo_range_seq cmo_range_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_lo(req_lo), .req_hi(req_hi), .done_valid(done_valid), .done_lo(done_lo),
  .arr_wb_req(arr_wb_req), .arr_wb_ack(arr_wb_ack), .arr_inv(arr_inv),
  .ic_inv(ic_inv), .op_q(op_q)
);

// File: tb/tb_cmo_range_seq.sv
module tb_cmo_range_seq;
  localparam int AW   = 32;
  localparam int LB   = 64;
  localparam int OFFW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_lo = '0, req_hi = '0;
  logic          done_valid;
  logic [AW-1:0] done_lo, arr_addr;
  logic          arr_probe, arr_hit, arr_dirty, arr_wb_req, arr_inv, ic_inv;
  logic          arr_wb_ack = 1'b0;

  // Behavioural array model: 16 sets, one line each.
  logic          mv [16];
  logic          md [16];
  logic [21:0]   mt [16];

  assign arr_hit   = mv[arr_addr[OFFW+3:OFFW]] && (mt[arr_addr[OFFW+3:OFFW]] == arr_addr[AW-1:OFFW+4]);
  assign arr_dirty = md[arr_addr[OFFW+3:OFFW]];

  cmo_range_seq #(.ADDR_W(AW), .LINE_BYTES(LB)) dut (.*);

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string what, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic set_line(input logic [AW-1:0] a, input bit v, input bit d);
    mv[a[OFFW+3:OFFW]] = v;
    md[a[OFFW+3:OFFW]] = d;
    mt[a[OFFW+3:OFFW]] = a[AW-1:OFFW+4];
  endtask

  // Vector: {ready, probe, wb_req, inv, ic_inv, done}
  task automatic run_req(input logic [1:0] op, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                         input int dly, input string tag, output logic [AW-1:0] res);
    logic [5:0] q[$];
    longint base, nxt;
    bit empty, partial, hit, dirty, wbn, invst;
    logic [AW-1:0] exp_lo;
    int wbc;
    base    = longint'(lo) & ~longint'(LB-1);
    nxt     = base + LB;
    empty   = (lo >= hi) || (op == 2'd3);
    partial = (longint'(lo) != base) || (longint'(hi) < nxt);
    hit     = mv[lo[OFFW+3:OFFW]] && (mt[lo[OFFW+3:OFFW]] == lo[AW-1:OFFW+4]);
    dirty   = md[lo[OFFW+3:OFFW]];
    wbn     = hit && dirty && (op == 2'd1 || op == 2'd2 || (op == 2'd0 && partial));
    invst   = (op == 2'd0 || op == 2'd2);
    exp_lo  = empty ? lo : AW'(nxt);
    if (!empty) begin
      q.push_back(6'b010000);
      if (wbn) for (int i = 0; i <= dly; i++) q.push_back(6'b001000);
      if (invst) q.push_back({3'b000, hit, 2'b10});
    end
    q.push_back(6'b000001);
    q.push_back(6'b100000);

    @(negedge clk);
    check(req_ready === 1'b1, {tag, " R1 ready before request"}, AW'(req_ready), 1);
    req_valid = 1'b1; req_op = op; req_lo = lo; req_hi = hi;
    @(negedge clk);
    req_valid = 1'b0;
    wbc = 0;
    foreach (q[k]) begin
      arr_wb_ack = arr_wb_req && (wbc == dly);
      if (arr_wb_req) wbc++;
      check({req_ready, arr_probe, arr_wb_req, arr_inv, ic_inv, done_valid} === q[k],
            $sformatf("%s cycle %0d", tag, k),
            AW'({req_ready, arr_probe, arr_wb_req, arr_inv, ic_inv, done_valid}), AW'(q[k]));
      if (done_valid) check(done_lo === exp_lo, {tag, " R3 done_lo"}, done_lo, exp_lo);
      if (done_valid) res = done_lo;
      if (arr_wb_req && arr_wb_ack) md[arr_addr[OFFW+3:OFFW]] = 1'b0;
      if (arr_inv) mv[arr_addr[OFFW+3:OFFW]] = 1'b0;
      if (k != q.size() - 1) @(negedge clk);
    end
    arr_wb_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=0 exp=1");
    finish_run();
  end

  initial begin : stim
    logic [AW-1:0] r, lo;
    int iters;
    for (int i = 0; i < 16; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({req_ready, arr_probe, arr_wb_req, arr_inv, ic_inv, done_valid} === 6'b100000,
          "R1 reset state", AW'({req_ready, arr_probe, arr_wb_req, arr_inv, ic_inv, done_valid}), AW'(6'b100000));

    run_req(2'd2, 32'h2000, 32'h2000, 0, "R2 lo equals hi", r);
    run_req(2'd0, 32'h3000, 32'h2000, 0, "R2 lo above hi", r);
    set_line(32'h4000, 1, 1);
    run_req(2'd3, 32'h4000, 32'h5000, 0, "R2 reserved op", r);

    run_req(2'd1, 32'h4000, 32'h5000, 2, "R4 R8 clean dirty hit", r);
    run_req(2'd1, 32'h4000, 32'h5000, 0, "R4 clean now-clean hit", r);
    run_req(2'd1, 32'h7040, 32'h9000, 0, "R4 clean miss", r);

    set_line(32'h5080, 1, 1);
    run_req(2'd2, 32'h5080, 32'h6000, 0, "R5 R9 flush dirty aligned", r);

    set_line(32'h60C0, 1, 1);
    run_req(2'd0, 32'h60C0, 32'h7000, 1, "R7 inval full dirty", r);

    set_line(32'h6100, 1, 1);
    run_req(2'd0, 32'h6104, 32'h7000, 3, "R6 R9 inval unaligned lo", r);

    set_line(32'h6140, 1, 1);
    run_req(2'd0, 32'h6140, 32'h6150, 1, "R6 inval hi inside line", r);

    run_req(2'd0, 32'h8180, 32'h9000, 0, "R10 inval miss", r);
    set_line(32'h81C0, 1, 0);
    run_req(2'd2, 32'h81C0, 32'h9000, 0, "R10 flush clean hit", r);

    lo = 32'h1010; iters = 0;
    while (lo < 32'h10C0 && iters < 10) begin
      run_req(2'd2, lo, 32'h10C0, 0, "R3 R11 range loop", r);
      lo = r; iters++;
    end
    check(iters == 3, "R3 loop iterations", AW'(iters), 3);
    check(lo == 32'h10C0, "R3 final lo", lo, 32'h10C0);

    finish_run();
  end
endmodule